// File: doc/BRIEF.md
# Word/Doubleword Integer ALU Decoder

This block is the combinational integer execute slice of a 64-bit RISC core. It receives one 32-bit instruction word together with the two 64-bit source register values the register file has already read for it. It recognises the register-register arithmetic, compare and logic operations, the 12-bit immediate forms of add, compare and logic, and a shift-then-add operation. It returns the 64-bit result, the destination register index, a write-enable and an illegal-opcode flag, all in the same cycle.

Word-sized operations are computed on the full operands. Their 32-bit result is then widened to 64 bits, by sign or zero extension as the opcode selects. Register index 0 is hard-wired to zero on the read side, and no write is ever requested for it. Register storage, multiply and divide, PC-relative forms and pipeline control sit outside this block. A parameter can remove the shift-add datapath, and the shift-add opcodes then decode as illegal.

Top module: `wdalu_top`

## Requirements
- R1: The doubleword add and subtract operations return rj+rk and rj-rk, modulo 2^64. Their opcodes in instruction bits 31:15 are 0x00021 (add) and 0x00023 (subtract). The fields are rk in bits 14:10, rj in bits 9:5 and rd in bits 4:0.
- R2: The word add (0x00020), word subtract (0x00022) and word add-immediate (bits 31:22 = 0x00A) compute on the full operands. They then copy bit 31 of the sum or difference into bits 63:32.
- R3: Compare ops write 1 when the relation holds and 0 otherwise. 0x00024 is signed rj<rk and 0x00025 is unsigned rj<rk. The immediate forms are bits 31:22 = 0x008 (signed) and 0x009 (unsigned). Both compare rj against the 12-bit immediate in bits 21:10, sign-extended to 64 bits.
- R4: The register logic ops are selected by bits 31:15. 0x00028 gives NOT(rj OR rk), 0x00029 gives AND, 0x0002A gives OR and 0x0002B gives XOR. 0x0002C gives rj OR NOT rk, and 0x0002D gives rj AND NOT rk.
- R5: The immediate logic ops use the 12-bit immediate zero-extended to 64 bits. Bits 31:22 = 0x00D is AND, 0x00E is OR and 0x00F is XOR.
- R6: The doubleword add-immediate (bits 31:22 = 0x00B) returns rj plus the sign-extended 12-bit immediate.
- R7: Shift-add returns (rj << s) + rk, where s is bits 16:15 plus one (1 to 4). Bits 31:17 select the form. 0x002 is word with the result's bit 31 sign-extended, 0x003 is word with bits 63:32 cleared, and 0x016 is the full 64-bit sum.
- R8: A source field holding index 0 reads as zero, whatever the value on the matching input bus.
- R9: A legal instruction asserts the write-enable exactly when its rd field is nonzero. With rd = 0 the write-enable stays low.
- R10: An instruction matching no listed encoding raises the illegal flag, drops the write-enable and drives the result to zero.
- R11: The destination index output always equals instruction bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word to execute |
| rj_val | input | XLEN | Value read for the rj field |
| rk_val | input | XLEN | Value read for the rk field |
| result | output | XLEN | Computed result, zero when illegal |
| rd_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Request to write result to rd |
| illegal | output | 1 | No encoding matched |

## Verification
Random source values seldom reach the shift-add word forms at their widest shift, where carries out of bit 31 must be kept or discarded depending on the form. Random values also seldom produce an unsigned compare against an immediate of all ones, which sign-extends to the largest 64-bit number. The stimulus builds these cases on purpose: it sets the shift field to its top value and drives operands near the 32-bit boundary. Separate cases put index 0 in a source field while the matching bus carries a nonzero value, and put index 0 in rd on an otherwise legal operation. Random instruction words with arbitrary opcode bits cover the illegal space, and the bench model works out which of them fall outside every encoding.

// File: rtl/wdalu_pkg.sv
package wdalu_pkg;

   localparam int INSN_W  = 32;
   localparam int IDX_W   = 5;
   localparam int IMM_W   = 12;
   localparam int SAF_W   = 2;
   localparam int SHAMT_W = SAF_W + 1;

   typedef enum logic [3:0] {
      K_ADD, K_SUB, K_SLT, K_SLTU, K_NOR, K_AND,
      K_OR, K_XOR, K_ORN, K_ANDN, K_SHADD
   } alu_kind_e;

   typedef enum logic [1:0] {
      X_NONE, X_SIGN, X_ZERO
   } ext_e;

   typedef struct packed {
      logic             legal;
      alu_kind_e        kind;
      ext_e             ext;
      logic             use_imm;
      logic             imm_sext;
      logic [SHAMT_W-1:0] shamt;
   } dec_t;

endpackage

// File: rtl/wdalu_decode.sv
module wdalu_decode
   import wdalu_pkg::*;
#(
   parameter bit HAS_SHADD = 1'b1
) (
   input  logic [INSN_W-1:0] instr,
   output dec_t              dec
);

   logic [16:0] op_rr;
   logic [14:0] op_sh;
   logic [9:0]  op_im;
   logic        sh_hit;
   ext_e        sh_ext;

   assign op_rr = instr[31:15];
   assign op_sh = instr[31:17];
   assign op_im = instr[31:22];

   generate
      if (HAS_SHADD) begin : g_shadd
         assign sh_hit = (op_sh == 15'h002) || (op_sh == 15'h003) || (op_sh == 15'h016);
         assign sh_ext = (op_sh == 15'h002) ? X_SIGN :
                         (op_sh == 15'h003) ? X_ZERO : X_NONE;
      end else begin : g_no_shadd
         assign sh_hit = 1'b0;
         assign sh_ext = X_NONE;
      end
   endgenerate

   always_comb begin
      dec          = '0;
      dec.kind     = K_ADD;
      dec.ext      = X_NONE;
      dec.legal    = 1'b1;
      dec.shamt    = {1'b0, instr[16:15]} + SHAMT_W'(1);
      unique case (op_rr)
         17'h00020: begin dec.kind = K_ADD;  dec.ext = X_SIGN; end
         17'h00021:       dec.kind = K_ADD;
         17'h00022: begin dec.kind = K_SUB;  dec.ext = X_SIGN; end
         17'h00023:       dec.kind = K_SUB;
         17'h00024:       dec.kind = K_SLT;
         17'h00025:       dec.kind = K_SLTU;
         17'h00028:       dec.kind = K_NOR;
         17'h00029:       dec.kind = K_AND;
         17'h0002A:       dec.kind = K_OR;
         17'h0002B:       dec.kind = K_XOR;
         17'h0002C:       dec.kind = K_ORN;
         17'h0002D:       dec.kind = K_ANDN;
         default: begin
            dec.use_imm  = 1'b1;
            dec.imm_sext = 1'b1;
            unique case (op_im)
               10'h008: dec.kind = K_SLT;
               10'h009: dec.kind = K_SLTU;
               10'h00A: begin dec.kind = K_ADD; dec.ext = X_SIGN; end
               10'h00B: dec.kind = K_ADD;
               10'h00D: begin dec.kind = K_AND; dec.imm_sext = 1'b0; end
               10'h00E: begin dec.kind = K_OR;  dec.imm_sext = 1'b0; end
               10'h00F: begin dec.kind = K_XOR; dec.imm_sext = 1'b0; end
               default: begin
                  dec.use_imm  = 1'b0;
                  dec.imm_sext = 1'b0;
                  if (sh_hit) begin
                     dec.kind = K_SHADD;
                     dec.ext  = sh_ext;
                  end else begin
                     dec.legal = 1'b0;
                  end
               end
            endcase
         end
      endcase
   end

endmodule

// File: rtl/wdalu_operands.sv
module wdalu_operands
   import wdalu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [INSN_W-1:0] instr,
   input  logic [XLEN-1:0]   rj_val,
   input  logic [XLEN-1:0]   rk_val,
   input  logic              use_imm,
   input  logic              imm_sext,
   output logic [XLEN-1:0]   opa,
   output logic [XLEN-1:0]   opb
);

   localparam int PAD_W = XLEN - IMM_W;

   logic [IDX_W-1:0] rj_idx;
   logic [IDX_W-1:0] rk_idx;
   logic [IMM_W-1:0] imm;
   logic [XLEN-1:0]  imm_ext;
   logic [XLEN-1:0]  rk_eff;

   assign rj_idx  = instr[9:5];
   assign rk_idx  = instr[14:10];
   assign imm     = instr[21:10];

   assign opa     = (rj_idx == '0) ? '0 : rj_val;
   assign rk_eff  = (rk_idx == '0) ? '0 : rk_val;
   assign imm_ext = imm_sext ? {{PAD_W{imm[IMM_W-1]}}, imm} : {{PAD_W{1'b0}}, imm};
   assign opb     = use_imm ? imm_ext : rk_eff;

endmodule

// File: rtl/wdalu_core.sv
module wdalu_core
   import wdalu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  alu_kind_e          kind,
   input  logic [SHAMT_W-1:0] shamt,
   input  logic [XLEN-1:0]    a,
   input  logic [XLEN-1:0]    b,
   output logic [XLEN-1:0]    raw
);

   logic [XLEN-1:0] shifted;

   assign shifted = a << shamt;

   always_comb begin
      unique case (kind)
         K_ADD:   raw = a + b;
         K_SUB:   raw = a - b;
         K_SLT:   raw = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
         K_SLTU:  raw = {{(XLEN-1){1'b0}}, a < b};
         K_NOR:   raw = ~(a | b);
         K_AND:   raw = a & b;
         K_OR:    raw = a | b;
         K_XOR:   raw = a ^ b;
         K_ORN:   raw = a | ~b;
         K_ANDN:  raw = a & ~b;
         K_SHADD: raw = shifted + b;
         default: raw = '0;
      endcase
   end

endmodule

// File: rtl/wdalu_extend.sv
module wdalu_extend
   import wdalu_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int WORD_W = 32
) (
   input  ext_e            ext,
   input  logic [XLEN-1:0] raw,
   output logic [XLEN-1:0] res
);

   localparam int HI_W = XLEN - WORD_W;

   always_comb begin
      unique case (ext)
         X_SIGN:  res = {{HI_W{raw[WORD_W-1]}}, raw[WORD_W-1:0]};
         X_ZERO:  res = {{HI_W{1'b0}}, raw[WORD_W-1:0]};
         default: res = raw;
      endcase
   end

endmodule

// File: rtl/wdalu_top.sv
module wdalu_top
   import wdalu_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int WORD_W    = 32,
   parameter bit HAS_SHADD = 1'b1
) (
   input  logic [INSN_W-1:0] instr,
   input  logic [XLEN-1:0]   rj_val,
   input  logic [XLEN-1:0]   rk_val,
   output logic [XLEN-1:0]   result,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              wr_en,
   output logic              illegal
);

   generate
      if (WORD_W < 32) begin : g_bad_word
         $error("WORD_W must be at least 32");
      end
      if (XLEN <= WORD_W) begin : g_bad_xlen
         $error("XLEN must exceed WORD_W");
      end
      if (XLEN <= IMM_W) begin : g_bad_imm
         $error("XLEN must exceed the immediate width");
      end
   endgenerate

   dec_t            dec;
   logic [XLEN-1:0] opa;
   logic [XLEN-1:0] opb;
   logic [XLEN-1:0] raw;
   logic [XLEN-1:0] ext_res;

   wdalu_decode #(.HAS_SHADD(HAS_SHADD)) u_dec (
      .instr (instr),
      .dec   (dec)
   );

   wdalu_operands #(.XLEN(XLEN)) u_ops (
      .instr    (instr),
      .rj_val   (rj_val),
      .rk_val   (rk_val),
      .use_imm  (dec.use_imm),
      .imm_sext (dec.imm_sext),
      .opa      (opa),
      .opb      (opb)
   );

   wdalu_core #(.XLEN(XLEN)) u_core (
      .kind  (dec.kind),
      .shamt (dec.shamt),
      .a     (opa),
      .b     (opb),
      .raw   (raw)
   );

   wdalu_extend #(.XLEN(XLEN), .WORD_W(WORD_W)) u_ext (
      .ext (dec.ext),
      .raw (raw),
      .res (ext_res)
   );

   assign rd_idx  = instr[4:0];
   assign illegal = ~dec.legal;
   assign wr_en   = dec.legal & (rd_idx != '0);
   assign result  = dec.legal ? ext_res : '0;

endmodule

// File: rtl/wdalu_checks.sv
module wdalu_checks
   import wdalu_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int WORD_W = 32
) (
   input logic [INSN_W-1:0] instr,
   input logic [XLEN-1:0]   result,
   input logic [IDX_W-1:0]  rd_idx,
   input logic              wr_en,
   input logic              illegal
);

   logic is_cmp;
   logic is_wadd;
   logic is_shz;

   assign is_cmp  = (instr[31:15] == 17'h00024) || (instr[31:15] == 17'h00025) ||
                    (instr[31:22] == 10'h008)   || (instr[31:22] == 10'h009);
   assign is_wadd = (instr[31:15] == 17'h00020);
   assign is_shz  = (instr[31:17] == 15'h003);

   always_comb begin
      assert_illegal_quiet_R10: assert (!illegal || (!wr_en && result == '0))
         else $error("illegal op left write or result active");
      assert_no_zero_write_R9: assert (!(wr_en && rd_idx == '0))
         else $error("write requested to index 0");
      assert_dest_field_R11: assert (rd_idx == instr[4:0])
         else $error("destination index mismatch");
      assert_cmp_boolean_R3: assert (!is_cmp || illegal || result[XLEN-1:1] == '0)
         else $error("compare result not 0 or 1");
      assert_word_sext_R2: assert (!is_wadd ||
                                   result[XLEN-1:WORD_W] == {(XLEN-WORD_W){result[WORD_W-1]}})
         else $error("word add upper bits not a sign copy");
      assert_word_zext_R7: assert (!is_shz || illegal || result[XLEN-1:WORD_W] == '0)
         else $error("zero-extended shift-add has upper bits set");
   end

endmodule

bind wdalu_top wdalu_checks #(.XLEN(XLEN), .WORD_W(WORD_W)) u_checks (
   .instr   (instr),
   .result  (result),
   .rd_idx  (rd_idx),
   .wr_en   (wr_en),
   .illegal (illegal)
);

// File: tb/tb_wdalu_top.sv
module tb_wdalu_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr = '0;
   logic [63:0] rj_val = '0;
   logic [63:0] rk_val = '0;
   logic [63:0] result;
   logic [4:0]  rd_idx;
   logic        wr_en;
   logic        illegal;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   wdalu_top dut (
      .instr   (instr),
      .rj_val  (rj_val),
      .rk_val  (rk_val),
      .result  (result),
      .rd_idx  (rd_idx),
      .wr_en   (wr_en),
      .illegal (illegal)
   );

   function automatic logic [63:0] sx32(input logic [63:0] v);
      return {{32{v[31]}}, v[31:0]};
   endfunction

   // {illegal, wr_en, result}
   function automatic logic [65:0] model(input logic [31:0] ins, input logic [63:0] jv,
                                         input logic [63:0] kv);
      logic [63:0] a, b, si, zi, r;
      logic        ok;
      a  = (ins[9:5] == 5'd0) ? 64'd0 : jv;
      b  = (ins[14:10] == 5'd0) ? 64'd0 : kv;
      si = {{52{ins[21]}}, ins[21:10]};
      zi = {52'd0, ins[21:10]};
      ok = 1'b1;
      r  = 64'd0;
      case (ins[31:15])
         17'h20: r = sx32(a + b);
         17'h21: r = a + b;
         17'h22: r = sx32(a - b);
         17'h23: r = a - b;
         17'h24: r = {63'd0, $signed(a) < $signed(b)};
         17'h25: r = {63'd0, a < b};
         17'h28: r = ~(a | b);
         17'h29: r = a & b;
         17'h2A: r = a | b;
         17'h2B: r = a ^ b;
         17'h2C: r = a | ~b;
         17'h2D: r = a & ~b;
         default:
            case (ins[31:22])
               10'h008: r = {63'd0, $signed(a) < $signed(si)};
               10'h009: r = {63'd0, a < si};
               10'h00A: r = sx32(a + si);
               10'h00B: r = a + si;
               10'h00D: r = a & zi;
               10'h00E: r = a | zi;
               10'h00F: r = a ^ zi;
               default:
                  case (ins[31:17])
                     15'h002: r = sx32((a << (ins[16:15] + 3'd1)) + b);
                     15'h003: r = {32'd0, 32'((a << (ins[16:15] + 3'd1)) + b)};
                     15'h016: r = (a << (ins[16:15] + 3'd1)) + b;
                     default: ok = 1'b0;
                  endcase
            endcase
      endcase
      return {~ok, ok && ins[4:0] != 5'd0, ok ? r : 64'd0};
   endfunction

   function automatic logic [31:0] enc_rr(input logic [16:0] op, input logic [4:0] d,
                                          input logic [4:0] j, input logic [4:0] k);
      return {op, k, j, d};
   endfunction

   function automatic logic [31:0] enc_im(input logic [9:0] op, input logic [4:0] d,
                                          input logic [4:0] j, input logic [11:0] im);
      return {op, im, j, d};
   endfunction

   function automatic logic [31:0] enc_sh(input logic [14:0] op, input logic [1:0] s,
                                          input logic [4:0] d, input logic [4:0] j,
                                          input logic [4:0] k);
      return {op, s, k, j, d};
   endfunction

   task automatic compare(input string tag, input logic [65:0] exp);
      checks++;
      if (result !== exp[63:0] || wr_en !== exp[64] || illegal !== exp[65] ||
          rd_idx !== instr[4:0]) begin
         errors++;
         $display("FAIL %s instr=%h got res=%h wen=%b ill=%b rd=%0d exp res=%h wen=%b ill=%b rd=%0d",
                  tag, instr, result, wr_en, illegal, rd_idx, exp[63:0], exp[64], exp[65], instr[4:0]);
      end
   endtask

   task automatic drive(input logic [31:0] ins, input logic [63:0] jv, input logic [63:0] kv);
      @(negedge clk);
      instr  = ins;
      rj_val = jv;
      rk_val = kv;
      #2;
   endtask

   task automatic run_lit(input string tag, input logic [31:0] ins, input logic [63:0] jv,
                          input logic [63:0] kv, input logic [63:0] er, input logic ew,
                          input logic ei);
      drive(ins, jv, kv);
      compare(tag, {ei, ew, er});
   endtask

   task automatic run_ref(input string tag, input logic [31:0] ins, input logic [63:0] jv,
                          input logic [63:0] kv);
      drive(ins, jv, kv);
      compare(tag, model(ins, jv, kv));
   endtask

   function automatic logic [63:0] rnd64();
      logic [63:0] v;
      v = {$urandom(), $urandom()};
      case ($urandom() % 6)
         0: v = 64'd0;
         1: v = 64'hFFFF_FFFF_FFFF_FFFF;
         2: v = 64'h0000_0000_7FFF_FFFF;
         3: v = 64'h8000_0000_0000_0000;
         default: ;
      endcase
      return v;
   endfunction

   initial begin : watchdog
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin : stim
      logic [16:0] rr_ops [12];
      logic [9:0]  im_ops [7];
      logic [14:0] sh_ops [3];
      logic [31:0] ins;
      rr_ops = '{17'h20, 17'h21, 17'h22, 17'h23, 17'h24, 17'h25,
                 17'h28, 17'h29, 17'h2A, 17'h2B, 17'h2C, 17'h2D};
      im_ops = '{10'h008, 10'h009, 10'h00A, 10'h00B, 10'h00D, 10'h00E, 10'h00F};
      sh_ops = '{15'h002, 15'h003, 15'h016};
      void'($urandom(32'd20240611));

      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R10: all-zero word after reset is not an encoding
      run_lit("R10 reset word", 32'h0, 64'd5, 64'd6, 64'd0, 1'b0, 1'b1);
      run_lit("R1 add.d wrap", enc_rr(17'h21, 5'd3, 5'd1, 5'd2),
              64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd1, 1'b1, 1'b0);
      run_lit("R1 sub.d", enc_rr(17'h23, 5'd3, 5'd1, 5'd2),
              64'd5, 64'd7, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 1'b0);
      run_lit("R2 add.w overflow", enc_rr(17'h20, 5'd4, 5'd1, 5'd2),
              64'h0000_0000_7FFF_FFFF, 64'd1, 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0);
      run_lit("R2 addi.w", enc_im(10'h00A, 5'd4, 5'd1, 12'hFFF),
              64'h1234_5678_0000_0000, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
      run_lit("R3 slt signed", enc_rr(17'h24, 5'd5, 5'd1, 5'd2),
              64'h8000_0000_0000_0000, 64'd1, 64'd1, 1'b1, 1'b0);
      run_lit("R3 sltu", enc_rr(17'h25, 5'd5, 5'd1, 5'd2),
              64'h8000_0000_0000_0000, 64'd1, 64'd0, 1'b1, 1'b0);
      run_lit("R3 sltui all-ones imm", enc_im(10'h009, 5'd5, 5'd1, 12'hFFF),
              64'hFFFF_FFFF_FFFF_FFFE, 64'd0, 64'd1, 1'b1, 1'b0);
      run_lit("R3 slti negative imm", enc_im(10'h008, 5'd5, 5'd1, 12'h800),
              64'd3, 64'd0, 64'd0, 1'b1, 1'b0);
      run_lit("R4 orn", enc_rr(17'h2C, 5'd6, 5'd1, 5'd2),
              64'd0, 64'hFFFF_FFFF_FFFF_FF00, 64'h0000_0000_0000_00FF, 1'b1, 1'b0);
      run_lit("R4 nor", enc_rr(17'h28, 5'd6, 5'd1, 5'd2),
              64'hF0, 64'h0F, 64'hFFFF_FFFF_FFFF_FF00, 1'b1, 1'b0);
      run_lit("R5 andi zero-ext", enc_im(10'h00D, 5'd7, 5'd1, 12'hFFF),
              64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'h0000_0000_0000_0FFF, 1'b1, 1'b0);
      run_lit("R6 addi.d", enc_im(10'h00B, 5'd7, 5'd1, 12'hFFF),
              64'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
      run_lit("R7 shadd zero-ext s=4", enc_sh(15'h003, 2'd3, 5'd8, 5'd1, 5'd2),
              64'h0000_0000_1FFF_FFFF, 64'd16, 64'h0000_0000_0000_0000, 1'b1, 1'b0);
      run_lit("R7 shadd sign s=1", enc_sh(15'h002, 2'd0, 5'd8, 5'd1, 5'd2),
              64'h0000_0000_4000_0000, 64'd1, 64'hFFFF_FFFF_8000_0001, 1'b1, 1'b0);
      run_lit("R7 shadd dword s=4", enc_sh(15'h016, 2'd3, 5'd8, 5'd1, 5'd2),
              64'h0000_0000_1FFF_FFFF, 64'd16, 64'h0000_0001_FFFF_FFF0 + 64'd16, 1'b1, 1'b0);
      run_lit("R8 rj index 0", enc_rr(17'h21, 5'd9, 5'd0, 5'd2),
              64'hDEAD_BEEF, 64'd7, 64'd7, 1'b1, 1'b0);
      run_lit("R8 rk index 0", enc_rr(17'h2A, 5'd9, 5'd3, 5'd0),
              64'h10, 64'hFFFF, 64'h10, 1'b1, 1'b0);
      run_lit("R9 rd index 0", enc_rr(17'h21, 5'd0, 5'd1, 5'd2),
              64'd1, 64'd2, 64'd3, 1'b0, 1'b0);
      run_lit("R10 all ones", 32'hFFFF_FFFF, 64'd1, 64'd2, 64'd0, 1'b0, 1'b1);
      run_lit("R11 rd passthrough", enc_rr(17'h29, 5'd31, 5'd1, 5'd2),
              64'hFF, 64'h0F, 64'h0F, 1'b1, 1'b0);

      for (int i = 0; i < 1500; i++) begin
         logic [4:0] d, j, k;
         d = 5'($urandom());
         j = 5'($urandom());
         k = 5'($urandom());
         case ($urandom() % 4)
            0: ins = enc_rr(rr_ops[$urandom() % 12], d, j, k);
            1: ins = enc_im(im_ops[$urandom() % 7], d, j, 12'($urandom()));
            2: ins = enc_sh(sh_ops[$urandom() % 3], 2'($urandom()), d, j, k);
            default: ins = $urandom();
         endcase
         run_ref("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random", ins, rnd64(), rnd64());
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule